// File: doc/BRIEF.md
# Multithreaded Thread Select Unit

This unit decides, every clock, which hardware thread feeds the next instruction into a pipeline that all threads share. Each thread has its own program counter inside the unit, so moving from one thread to another needs no save or restore step. The unit reports the chosen thread, that thread's current program counter and a valid flag. When a thread is issued, its counter moves forward by a fixed step. A redirect input can instead load a new address into any one thread's counter.

There are two policies, chosen by a mode pin. In interleaved mode the unit moves to a new thread on every clock, in rotating order, and passes over any thread that is blocked. In switch-on-miss mode one thread keeps the pipeline until it reports a costly stall, such as a miss in the outer cache. The unit then requests a pipeline drain, moves ownership to another thread, and holds issue off for a fixed number of refill cycles.

The issue side has a valid flag but no ready input. Back-pressure from the pipeline reaches the unit only through the per-thread blocking inputs: a thread whose short-stall bit is set is not issued in that cycle. Inputs are sampled on the rising clock edge. The select outputs are combinational from the registered state and the blocking inputs of the same cycle.

Top module: `tsel_top`

## Requirements
- R1: After reset the unit is in interleaved mode, the rotation starts at thread 0, and thread t's counter holds RST_BASE + t*RST_STRIDE (defaults 0x1000 and 0x100). With nothing blocked, the first cycle issues thread 0 at address 0x1000.
- R2: In interleaved mode with no thread blocked, the issued thread ID goes 0, 1, 2, 3, 0, … and changes every clock.
- R3: A thread is blocked in a cycle when its bit in `stall_vec` or in `miss_vec` is 1. In interleaved mode a blocked thread is skipped, and `issue_valid` is never 1 for a blocked thread.
- R4: In interleaved mode, when every thread is blocked, `issue_valid` is 0 and the rotation point holds. Issue then resumes with the thread that followed the last one issued.
- R5: Each issue adds PC_STEP (default 4) to the issued thread's counter only. The counters of the other threads are unchanged.
- R6: When `redir_en` is 1, the counter of thread `redir_tid` is loaded with `redir_pc` at the clock edge. This takes priority over the step increment in the same cycle.
- R7: In switch-on-miss mode the owning thread issues on every cycle in which it is not blocked. A short stall (`stall_vec` bit of the owner) gives `issue_valid` = 0 with no change of owner and no drain.
- R8: In switch-on-miss mode, when the owner's `miss_vec` bit is 1 and no refill is in progress, the unit looks for another thread, searching in rotating order from owner+1. If it finds one, `drain_req` is 1 for one cycle with `issue_valid` = 0, and `issue_tid` shows the new owner from the next cycle on.
- R9: After a drain cycle, `issue_valid` stays 0 for exactly REFILL_CYC cycles (default 3). Cost-stall inputs are ignored during those cycles. Issue then resumes on the new owner.
- R10: In switch-on-miss mode, when the owner's `miss_vec` bit is 1 and every other thread is blocked, the owner is kept, `drain_req` stays 0 and `issue_valid` is 0.
- R11: `mode_sel` (0 = interleaved, 1 = switch-on-miss) is taken at a clock edge only when the current cycle is neither a drain cycle nor a refill cycle. The new mode applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 interleaved, 1 switch-on-miss |
| stall_vec | input | NTHR | Per-thread short-stall flags |
| miss_vec | input | NTHR | Per-thread costly-stall flags |
| redir_en | input | 1 | Load a thread counter this cycle |
| redir_tid | input | TW | Thread whose counter is loaded |
| redir_pc | input | PCW | Address to load |
| issue_valid | output | 1 | An instruction from `issue_tid` is issued this cycle |
| issue_tid | output | TW | Selected thread (the owner while idle) |
| issue_pc | output | PCW | Current counter of `issue_tid` |
| drain_req | output | 1 | Pipeline drain request on an ownership change |

## Verification
`issue_valid`, `issue_tid`, `issue_pc` and `drain_req` respond to the blocking inputs in the same cycle. Counter updates, redirects, ownership changes and mode changes show up one edge after the cycle that causes them. After a drain, the idle window lasts REFILL_CYC cycles before issue resumes. The bench drives all inputs just after the falling edge and compares the outputs one time unit later, before the next rising edge. Each expected value is therefore tied to a known cycle, counted from reset or from the drain cycle.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic {
    TS_FINE   = 1'b0,
    TS_COARSE = 1'b1
  } tsel_mode_e;
endpackage

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
  parameter int NTHR = 4,
  parameter int TW   = 2
) (
  input  logic [TW-1:0]   start,
  input  logic [NTHR-1:0] cand,
  output logic            found,
  output logic [TW-1:0]   pick
);
  // walk offsets from the far end so the nearest candidate is written last
  always_comb begin
    logic [TW:0] s;
    found = 1'b0;
    pick  = start;
    for (int k = NTHR - 1; k >= 0; k--) begin
      s = {1'b0, start} + (TW+1)'(k);
      if (s >= (TW+1)'(NTHR)) s = s - (TW+1)'(NTHR);
      if (cand[s[TW-1:0]]) begin
        found = 1'b1;
        pick  = s[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/tsel_pc_bank.sv
module tsel_pc_bank #(
  parameter int NTHR = 4,
  parameter int TW   = 2,
  parameter int PCW  = 32,
  parameter logic [PCW-1:0] RST_BASE   = 'h1000,
  parameter logic [PCW-1:0] RST_STRIDE = 'h100,
  parameter int unsigned PC_STEP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_en,
  input  logic [TW-1:0]  adv_tid,
  input  logic           redir_en,
  input  logic [TW-1:0]  redir_tid,
  input  logic [PCW-1:0] redir_pc,
  input  logic [TW-1:0]  rd_tid,
  output logic [PCW-1:0] rd_pc
);
  localparam logic [PCW-1:0] STEP = PCW'(PC_STEP);

  logic [PCW-1:0] pc_q [NTHR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) pc_q[t] <= RST_BASE + PCW'(t) * RST_STRIDE;
    end else begin
      if (adv_en)   pc_q[adv_tid]   <= pc_q[adv_tid] + STEP;
      if (redir_en) pc_q[redir_tid] <= redir_pc;
    end
  end

  assign rd_pc = pc_q[rd_tid];

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !(redir_en && redir_tid == adv_tid))
      |=> pc_q[$past(adv_tid)] == $past(pc_q[adv_tid]) + STEP);

  // R6
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_en |=> pc_q[$past(redir_tid)] == $past(redir_pc));
endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int PCW  = 32,
  parameter int REFILL_CYC = 3,
  parameter logic [PCW-1:0] RST_BASE   = 'h1000,
  parameter logic [PCW-1:0] RST_STRIDE = 'h100,
  parameter int unsigned PC_STEP = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sel,
  input  logic [NTHR-1:0] stall_vec,
  input  logic [NTHR-1:0] miss_vec,
  input  logic            redir_en,
  input  logic [TW-1:0]   redir_tid,
  input  logic [PCW-1:0]  redir_pc,
  output logic            issue_valid,
  output logic [TW-1:0]   issue_tid,
  output logic [PCW-1:0]  issue_pc,
  output logic            drain_req
);
  localparam int CW = $clog2(REFILL_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(NTHR - 1);

  tsel_mode_e      mode_q;
  logic [TW-1:0]   cur_q;
  logic [CW-1:0]   cnt_q;
  logic [NTHR-1:0] avail, other_avail, own_mask;
  logic [TW-1:0]   cur_nxt, f_pick, c_pick;
  logic            f_found, c_found, refilling;

  assign avail     = ~(stall_vec | miss_vec);
  assign refilling = (cnt_q != '0);
  assign cur_nxt   = (cur_q == LAST) ? '0 : cur_q + TW'(1);

  always_comb begin
    own_mask = '0;
    own_mask[cur_q] = 1'b1;
  end
  assign other_avail = avail & ~own_mask;

  tsel_rr_pick #(.NTHR(NTHR), .TW(TW)) i_fine_pick (
    .start(cur_q), .cand(avail), .found(f_found), .pick(f_pick)
  );

  tsel_rr_pick #(.NTHR(NTHR), .TW(TW)) i_coarse_pick (
    .start(cur_nxt), .cand(other_avail), .found(c_found), .pick(c_pick)
  );

  always_comb begin
    issue_valid = 1'b0;
    issue_tid   = cur_q;
    drain_req   = 1'b0;
    if (!refilling) begin
      if (mode_q == TS_FINE) begin
        if (f_found) begin
          issue_valid = 1'b1;
          issue_tid   = f_pick;
        end
      end else if (miss_vec[cur_q]) begin
        drain_req = c_found;
      end else begin
        issue_valid = !stall_vec[cur_q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TS_FINE;
      cur_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (drain_req) begin
        cur_q <= c_pick;
        cnt_q <= CW'(REFILL_CYC);
      end else if (refilling) begin
        cnt_q <= cnt_q - CW'(1);
      end
      if (mode_q == TS_FINE && issue_valid)
        cur_q <= (f_pick == LAST) ? '0 : f_pick + TW'(1);
      if (!refilling && !drain_req)
        mode_q <= mode_sel ? TS_COARSE : TS_FINE;
    end
  end

  tsel_pc_bank #(
    .NTHR(NTHR), .TW(TW), .PCW(PCW),
    .RST_BASE(RST_BASE), .RST_STRIDE(RST_STRIDE), .PC_STEP(PC_STEP)
  ) i_pc_bank (
    .clk(clk), .rst_n(rst_n),
    .adv_en(issue_valid), .adv_tid(issue_tid),
    .redir_en(redir_en), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .rd_tid(issue_tid), .rd_pc(issue_pc)
  );

  // R3
  valid_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !(stall_vec[issue_tid] || miss_vec[issue_tid]));

  // R8
  drain_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |=> issue_tid != $past(issue_tid));

  // R9
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |=> !issue_valid && !drain_req);

  // R7
  coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TS_COARSE && !drain_req)
      |=> (mode_q != TS_COARSE || issue_tid == $past(issue_tid)));
endmodule

// File: tb/test_tsel_top.sv
module test_tsel_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 4;
  localparam int TW = 2;
  localparam int PCW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mode_sel;
  logic [NTHR-1:0] stall_vec, miss_vec;
  logic            redir_en;
  logic [TW-1:0]   redir_tid;
  logic [PCW-1:0]  redir_pc;
  logic            issue_valid;
  logic [TW-1:0]   issue_tid;
  logic [PCW-1:0]  issue_pc;
  logic            drain_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsel_top i_tsel_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .stall_vec(stall_vec), .miss_vec(miss_vec),
    .redir_en(redir_en), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .issue_valid(issue_valid), .issue_tid(issue_tid),
    .issue_pc(issue_pc), .drain_req(drain_req)
  );

  // compare outputs; pc only when an issue is expected
  task automatic expect_out(string req, bit ev, int et, logic [PCW-1:0] ep, bit ed);
    #1;
    n_vec++;
    if (issue_valid !== ev || issue_tid !== TW'(et) || drain_req !== ed ||
        (ev && issue_pc !== ep)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b tid=%0d pc=%h drain=%0b, exp v=%0b tid=%0d pc=%h drain=%0b",
               req, issue_valid, issue_tid, issue_pc, drain_req, ev, et, ep, ed);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(bit m, logic [NTHR-1:0] st);
    rst_n = 1'b0; mode_sel = m; stall_vec = st; miss_vec = '0;
    redir_en = 1'b0; redir_tid = '0; redir_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_fine_rotate();
    logic [PCW-1:0] pcs [5] = '{32'h1000, 32'h1100, 32'h1200, 32'h1300, 32'h1004};
    do_reset(1'b0, '0);
    expect_out("R1", 1'b1, 0, 32'h1000, 1'b0);
    for (int i = 1; i < 5; i++) expect_out("R2", 1'b1, i % 4, pcs[i], 1'b0);
    expect_out("R5", 1'b1, 1, 32'h1104, 1'b0);
  endtask

  task automatic t_fine_skip();
    do_reset(1'b0, '0);
    stall_vec = 4'b0010; miss_vec = 4'b1000;
    expect_out("R3", 1'b1, 0, 32'h1000, 1'b0);
    expect_out("R3", 1'b1, 2, 32'h1200, 1'b0);
    expect_out("R3", 1'b1, 0, 32'h1004, 1'b0);
    expect_out("R3", 1'b1, 2, 32'h1204, 1'b0);
  endtask

  task automatic t_all_blocked();
    do_reset(1'b0, '0);
    expect_out("R1", 1'b1, 0, 32'h1000, 1'b0);
    stall_vec = 4'b1111;
    expect_out("R4", 1'b0, 1, 32'h0, 1'b0);
    expect_out("R4", 1'b0, 1, 32'h0, 1'b0);
    stall_vec = '0;
    expect_out("R4", 1'b1, 1, 32'h1100, 1'b0);
  endtask

  task automatic t_redirect();
    do_reset(1'b0, '0);
    redir_en = 1'b1; redir_tid = 2'd0; redir_pc = 32'h8000;
    expect_out("R6", 1'b1, 0, 32'h1000, 1'b0);
    redir_tid = 2'd2; redir_pc = 32'h9000;
    expect_out("R6", 1'b1, 1, 32'h1100, 1'b0);
    redir_en = 1'b0;
    expect_out("R6", 1'b1, 2, 32'h9000, 1'b0);
    expect_out("R5", 1'b1, 3, 32'h1300, 1'b0);
    expect_out("R6", 1'b1, 0, 32'h8000, 1'b0);
    expect_out("R5", 1'b1, 1, 32'h1104, 1'b0);
  endtask

  task automatic t_coarse();
    do_reset(1'b1, 4'b1111);
    expect_out("R4", 1'b0, 0, 32'h0, 1'b0);
    stall_vec = '0;
    expect_out("R7", 1'b1, 0, 32'h1000, 1'b0);
    expect_out("R7", 1'b1, 0, 32'h1004, 1'b0);
    expect_out("R7", 1'b1, 0, 32'h1008, 1'b0);
    stall_vec = 4'b0001;
    expect_out("R7", 1'b0, 0, 32'h0, 1'b0);
    stall_vec = '0;
    expect_out("R7", 1'b1, 0, 32'h100C, 1'b0);
    miss_vec = 4'b0011;
    expect_out("R8", 1'b0, 0, 32'h0, 1'b1);
    for (int i = 0; i < 3; i++) expect_out("R9", 1'b0, 2, 32'h0, 1'b0);
    expect_out("R9", 1'b1, 2, 32'h1200, 1'b0);
    expect_out("R9", 1'b1, 2, 32'h1204, 1'b0);
    miss_vec = 4'b1111;
    expect_out("R10", 1'b0, 2, 32'h0, 1'b0);
    expect_out("R10", 1'b0, 2, 32'h0, 1'b0);
    miss_vec = 4'b0100; mode_sel = 1'b0;
    expect_out("R8", 1'b0, 2, 32'h0, 1'b1);
    miss_vec = '0;
    for (int i = 0; i < 3; i++) expect_out("R11", 1'b0, 3, 32'h0, 1'b0);
    expect_out("R11", 1'b1, 3, 32'h1300, 1'b0);
    expect_out("R11", 1'b1, 3, 32'h1304, 1'b0);
    expect_out("R11", 1'b1, 0, 32'h1010, 1'b0);
    expect_out("R11", 1'b1, 1, 32'h1100, 1'b0);
  endtask

  initial begin
    t_fine_rotate();
    t_fine_skip();
    t_all_blocked();
    t_redirect();
    t_coarse();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule